// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block watches the boundary between the register-read stage and the execute stage of a five-stage in-order pipeline (fetch, register read, execute, memory, writeback). Load data only exists at the end of the memory stage. An instruction that reads a load's target in the very next slot would therefore see stale data in execute. The block compares the source register fields of the register-read instruction with the destination of the load now in execute. On a hit it freezes the program counter and the fetch/read pipeline register for one cycle. It then sends a non-executing slot into execute in place of the dependent instruction.

The block owns the control half of the read/execute pipeline register. Each cycle it captures the register-read stage's control word: valid, register-write, memory-write, load flag and destination field. When a bubble is injected, it writes a cleared word instead. The bubble is not removed from the pipe. It travels down the remaining stages with its valid and write-enable bits low, so it changes no architectural state. Forwarding, the register file and memory sit outside this block.

Top module: `load_use_stall`

## Requirements
- R1: After synchronous reset the execute control word is all zero (valid, register-write, memory-write, load, destination), and `pc_hold`, `ifrd_hold` and `bubble` are 0.
- R2: `pc_hold`, `ifrd_hold` and `bubble` are 1 in the same cycle, combinationally, when all of these hold: the execute entry is a valid load with register-write set and a nonzero destination; the register-read entry is valid; and some source whose use flag is 1 equals that destination.
- R3: A load whose destination is register 0 never raises a stall.
- R4: A source field whose use flag is 0 never causes a stall, whatever its value.
- R5: An execute entry that is not a load (load flag 0), or is a load with register-write 0, never raises a stall.
- R6: A register-read entry with valid 0 never raises a stall.
- R7: In the cycle after `bubble` is 1, the execute control word is all zero.
- R8: In the cycle after a clock edge with no stall, the execute control word equals the register-read control word that was presented at that edge.
- R9: A stall lasts exactly one cycle. If the pipeline holds the register-read entry, a second dependent instruction right behind the load gets no further stall cycle.
- R10: `pc_hold`, `ifrd_hold` and `bubble` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Register-read entry is a real instruction |
| rd_src | input | NSRC*5 | Source register fields of the register-read entry, index 0 = first source |
| rd_src_use | input | NSRC | Use flag for each source field |
| rd_load | input | 1 | Register-read entry is a load |
| rd_reg_wr | input | 1 | Register-read entry writes a register |
| rd_mem_wr | input | 1 | Register-read entry writes memory |
| rd_dst | input | 5 | Destination register of the register-read entry |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifrd_hold | output | 1 | Keep the fetch/read pipeline register unchanged this cycle |
| bubble | output | 1 | Execute receives a cleared control word at the next edge |
| ex_valid | output | 1 | Execute entry valid |
| ex_reg_wr | output | 1 | Execute entry register-write |
| ex_mem_wr | output | 1 | Execute entry memory-write |
| ex_load | output | 1 | Execute entry is a load |
| ex_dst | output | 5 | Execute entry destination register |

## Verification
The hardest case to reach from the ports is a load followed by two dependent instructions back to back. It works only if the stimulus behaves like a real fetch stage and presents the same register-read entry again while the hold is up. The bench's reference model decides the hold itself and replays the frozen entry on the next cycle, so it checks that the retried instruction meets a bubble rather than the load. Register 0 and unused-source cases are hard to hit at random, so a narrow register range and directed sequences put them next to real matches.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Width of a register specifier
    localparam int REG_AW = 5;

    // Control word carried from register read into execute
    typedef struct packed {
        logic              valid;
        logic              reg_wr;
        logic              mem_wr;
        logic              load;
        logic [REG_AW-1:0] dst;
    } ctl_t;

    // A non-executing slot: every enable and the destination cleared
    function automatic ctl_t ctl_empty();
        ctl_t c;
        c.valid  = 1'b0;
        c.reg_wr = 1'b0;
        c.mem_wr = 1'b0;
        c.load   = 1'b0;
        c.dst    = '0;
        return c;
    endfunction

    // Is this entry a load whose result would be consumed by a register read?
    function automatic logic ctl_is_producing_load(ctl_t c);
        return c.valid && c.load && c.reg_wr && (c.dst != '0);
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int AW = hz_pkg::REG_AW
) (
    input  logic          src_use,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] load_dst,
    output logic          hit
);
    // A field only counts when the instruction really reads it
    always_comb begin
        hit = src_use && (src == load_dst);
    end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  ctl_t            ex_ctl,
    input  logic            rd_valid,
    input  logic [NSRC-1:0] src_hit,
    output logic            stall
);
    logic load_live;
    logic any_hit;

    always_comb begin
        load_live = ctl_is_producing_load(ex_ctl);
        any_hit   = |src_hit;
        stall     = load_live && rd_valid && any_hit;
    end

    // R3
    always_ff @(posedge clk) begin
        if (!rst && ex_ctl.dst == '0)
            zero_dst_chk: assert (!stall) else $error("stall on register 0 load");
    end

    // R5
    always_ff @(posedge clk) begin
        if (!rst && !(ex_ctl.load && ex_ctl.reg_wr))
            non_load_chk: assert (!stall) else $error("stall without a writing load");
    end
endmodule

// File: rtl/hz_exreg.sv
module hz_exreg
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bubble,
    input  ctl_t rd_ctl,
    output ctl_t ex_ctl
);
    ctl_t ex_q;

    always_ff @(posedge clk) begin
        if (rst)
            ex_q <= ctl_empty();
        else if (bubble)
            ex_q <= ctl_empty();
        else
            ex_q <= rd_ctl;
    end

    assign ex_ctl = ex_q;

    // R7
    bubble_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (!ex_ctl.valid && !ex_ctl.reg_wr && !ex_ctl.mem_wr && !ex_ctl.load))
        else $error("bubble did not clear execute word");

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !bubble |=> (ex_ctl == $past(rd_ctl)))
        else $error("execute word differs from captured entry");
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_valid,
    input  logic [NSRC-1:0][REG_AW-1:0]  rd_src,
    input  logic [NSRC-1:0]              rd_src_use,
    input  logic                         rd_load,
    input  logic                         rd_reg_wr,
    input  logic                         rd_mem_wr,
    input  logic [REG_AW-1:0]            rd_dst,
    output logic                         pc_hold,
    output logic                         ifrd_hold,
    output logic                         bubble,
    output logic                         ex_valid,
    output logic                         ex_reg_wr,
    output logic                         ex_mem_wr,
    output logic                         ex_load,
    output logic [REG_AW-1:0]            ex_dst
);
    ctl_t            rd_ctl;
    ctl_t            ex_ctl;
    logic [NSRC-1:0] src_hit;
    logic            stall;

    always_comb begin
        rd_ctl.valid  = rd_valid;
        rd_ctl.reg_wr = rd_reg_wr;
        rd_ctl.mem_wr = rd_mem_wr;
        rd_ctl.load   = rd_load;
        rd_ctl.dst    = rd_dst;
    end

    // One comparator per source field
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_match #(.AW(REG_AW)) u_match (
            .src_use  (rd_src_use[g]),
            .src      (rd_src[g]),
            .load_dst (ex_ctl.dst),
            .hit      (src_hit[g])
        );
    end

    hz_detect #(.NSRC(NSRC)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .ex_ctl   (ex_ctl),
        .rd_valid (rd_valid),
        .src_hit  (src_hit),
        .stall    (stall)
    );

    hz_exreg u_exreg (
        .clk    (clk),
        .rst    (rst),
        .bubble (stall),
        .rd_ctl (rd_ctl),
        .ex_ctl (ex_ctl)
    );

    assign pc_hold   = stall;
    assign ifrd_hold = stall;
    assign bubble    = stall;
    assign ex_valid  = ex_ctl.valid;
    assign ex_reg_wr = ex_ctl.reg_wr;
    assign ex_mem_wr = ex_ctl.mem_wr;
    assign ex_load   = ex_ctl.load;
    assign ex_dst    = ex_ctl.dst;

    // R9
    stall_once_chk: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> !pc_hold)
        else $error("stall held for two cycles");

    // R6
    idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> !pc_hold)
        else $error("stall for an invalid read entry");
endmodule

// File: tb/test_load_use_stall.sv
module test_load_use_stall;
    localparam int NSRC = 2;
    localparam int AW   = 5;

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      rd_valid;
    logic [NSRC-1:0][AW-1:0]   rd_src;
    logic [NSRC-1:0]           rd_src_use;
    logic                      rd_load, rd_reg_wr, rd_mem_wr;
    logic [AW-1:0]             rd_dst;
    logic                      pc_hold, ifrd_hold, bubble;
    logic                      ex_valid, ex_reg_wr, ex_mem_wr, ex_load;
    logic [AW-1:0]             ex_dst;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model of the execute entry
    int m_valid, m_rw, m_mw, m_ld, m_dst;
    int m_stall_prev;

    always #4 clk = ~clk;

    load_use_stall #(.NSRC(NSRC)) i_load_use_stall (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_src(rd_src),
        .rd_src_use(rd_src_use), .rd_load(rd_load), .rd_reg_wr(rd_reg_wr),
        .rd_mem_wr(rd_mem_wr), .rd_dst(rd_dst), .pc_hold(pc_hold),
        .ifrd_hold(ifrd_hold), .bubble(bubble), .ex_valid(ex_valid),
        .ex_reg_wr(ex_reg_wr), .ex_mem_wr(ex_mem_wr), .ex_load(ex_load),
        .ex_dst(ex_dst)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_stall();
        int h = 0;
        if (m_valid != 0 && m_ld != 0 && m_rw != 0 && m_dst != 0 && rd_valid) begin
            for (int i = 0; i < NSRC; i++)
                if (rd_src_use[i] && int'(rd_src[i]) == m_dst) h = 1;
        end
        return h;
    endfunction

    // requirement that decides the expected stall in this cycle
    function automatic string stall_tag();
        int any = 0, anyraw = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (int'(rd_src[i]) == m_dst) anyraw = 1;
            if (rd_src_use[i] && int'(rd_src[i]) == m_dst) any = 1;
        end
        if (m_valid != 0 && m_ld != 0 && m_rw != 0 && m_dst == 0) return "R3";
        if (m_ld == 0 || m_rw == 0) return "R5";
        if (!rd_valid) return "R6";
        if (anyraw && !any) return "R4";
        if (m_stall_prev != 0) return "R9";
        return "R2";
    endfunction

    // present one entry, check mid-cycle, then advance the model at the edge
    task automatic cycle(input bit v, input int s0, input int s1, input bit u0,
                         input bit u1, input bit ld, input bit rw, input bit mw,
                         input int d);
        int es;
        rd_valid = v; rd_src[0] = AW'(s0); rd_src[1] = AW'(s1);
        rd_src_use = {u1, u0}; rd_load = ld; rd_reg_wr = rw;
        rd_mem_wr = mw; rd_dst = AW'(d);
        #2;
        es = exp_stall();
        check(stall_tag(), int'(pc_hold), es);
        check("R10", int'(ifrd_hold), int'(pc_hold));
        check("R10", int'(bubble), int'(pc_hold));
        check(m_stall_prev != 0 ? "R7" : "R8", int'(ex_valid), m_valid);
        check(m_stall_prev != 0 ? "R7" : "R8", int'(ex_reg_wr), m_rw);
        check(m_stall_prev != 0 ? "R7" : "R8", int'(ex_mem_wr), m_mw);
        check(m_stall_prev != 0 ? "R7" : "R8", int'(ex_load), m_ld);
        check(m_stall_prev != 0 ? "R7" : "R8", int'(ex_dst), m_dst);
        @(posedge clk);
        if (es != 0) begin
            m_valid = 0; m_rw = 0; m_mw = 0; m_ld = 0; m_dst = 0;
        end else begin
            m_valid = v; m_rw = rw; m_mw = mw; m_ld = ld; m_dst = d;
        end
        m_stall_prev = es;
        @(negedge clk);
    endtask

    // issue an entry; replay it while the model says the front end is held
    task automatic issue(input bit v, input int s0, input int s1, input bit u0,
                         input bit u1, input bit ld, input bit rw, input bit mw,
                         input int d);
        cycle(v, s0, s1, u0, u1, ld, rw, mw, d);
        while (m_stall_prev != 0) cycle(v, s0, s1, u0, u1, ld, rw, mw, d);
    endtask

    initial begin
        int stalls;
        rst = 1'b1;
        rd_valid = 1'b0; rd_src = '0; rd_src_use = '0;
        rd_load = 1'b0; rd_reg_wr = 1'b0; rd_mem_wr = 1'b0; rd_dst = '0;
        m_valid = 0; m_rw = 0; m_mw = 0; m_ld = 0; m_dst = 0; m_stall_prev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state right after reset
        check("R1", int'(ex_valid), 0);
        check("R1", int'(ex_reg_wr | ex_mem_wr | ex_load), 0);
        check("R1", int'(ex_dst), 0);
        check("R1", int'(pc_hold | ifrd_hold | bubble), 0);
        rst = 1'b0;

        // R2: load r3 then an add reading r3 on its second source
        issue(1, 1, 0, 1, 0, 1, 1, 0, 3);
        cycle(1, 2, 3, 1, 1, 0, 1, 0, 4);
        check("R2", m_stall_prev, 1);
        cycle(1, 2, 3, 1, 1, 0, 1, 0, 4);
        // R9: load r5, then two dependents back to back, one stall total
        issue(1, 0, 0, 0, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 1, 0, 1, 1, 0, 5);
        stalls = 0;
        cycle(1, 5, 0, 1, 0, 0, 1, 0, 6); stalls += m_stall_prev;
        cycle(1, 5, 0, 1, 0, 0, 1, 0, 6); stalls += m_stall_prev;
        cycle(1, 5, 5, 1, 1, 0, 1, 0, 7); stalls += m_stall_prev;
        check("R9", stalls, 1);
        // R3: load to register 0 followed by a reader of register 0
        cycle(1, 1, 0, 1, 0, 1, 1, 0, 0);
        cycle(1, 0, 0, 1, 1, 0, 1, 0, 2);
        // R4: matching field with use flag clear
        cycle(1, 1, 0, 1, 0, 1, 1, 0, 6);
        cycle(1, 6, 6, 0, 0, 0, 1, 1, 2);
        // R5: ALU result and non-writing load ahead of a reader
        cycle(1, 1, 0, 1, 0, 0, 1, 0, 7);
        cycle(1, 7, 0, 1, 0, 0, 1, 0, 2);
        cycle(1, 1, 0, 1, 0, 1, 0, 0, 8);
        cycle(1, 8, 8, 1, 1, 0, 1, 0, 2);
        // R6: invalid read entry behind a load
        cycle(1, 1, 0, 1, 0, 1, 1, 0, 9);
        cycle(0, 9, 9, 1, 1, 0, 1, 0, 2);

        // random traffic over a narrow register range
        for (int n = 0; n < 3000; n++) begin
            issue(($urandom % 10) != 0, $urandom % 4, $urandom % 4,
                  1'($urandom), 1'($urandom), ($urandom % 5) < 2,
                  ($urandom % 4) != 0, 1'($urandom), $urandom % 4);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done == 1);
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule